// File: doc/BRIEF.md
# Bus Error Detection Status Register

This block observes the control traffic of a shared system bus from one node's point of view and records each class of detected error as a sticky flag in a 32-bit status word. It covers the following error classes:

- a commander waiting too long for data to start;
- a mismatch between the status-check line and the shared/dirty lines;
- an out-of-order transfer sequence number;
- a difference between what this node drove and what the bus carried, on either the data-control group or the address-side group;
- a command acknowledge that no outstanding command accounts for;
- a data transmit-check failure that no ECC error explains.

A separate status-only flag records that this node was the data transmitter when a data-error indication arrived.

Software reads the word through a plain read port and clears flags by writing ones to them. Every flag except the status-only one is fatal and holds the system fault output high until software has cleared all fatal flags. The timeout can be suppressed through a disable input that comes from a control register elsewhere.

Top module: `bus_err_status`

## Requirements
- R1: After reset, rd_data_o reads 0 and fault_o is low.
- R2: A write with wr_en_i clears exactly the flags whose wr_data_i bits are 1 and leaves the others unchanged. A flag that hardware sets in the same cycle as a write that clears it stays set.
- R3: Bit 31 sets when a wait begins (wait_start_i sampled high) and send_data_i is not seen during the next TIMEOUT_CYC clock edges. A new wait_start_i restarts the count, send_data_i ends the wait, and the flag never sets while timeout_dis_i is high.
- R4: Bit 30 sets when stat_valid_i is high and statchk_i differs from shared_i OR dirty_i.
- R5: Bit 29 sets when seq_valid_i is high and seq_i differs from the expected number. The expected number is 0 after reset and advances by one, modulo 16, on every seq_valid_i cycle.
- R6: Bit 28 sets when any dc_drv_en_i bit is 1 and the matching dc_drv_i and dc_obs_i bits differ. The 10-bit layout is: bit 0 send-data, bits 4:1 sequence, bit 5 shared, bit 6 dirty, bit 7 hold, bit 8 status-check, bit 9 data-error.
- R7: Bit 27 sets when any ab_drv_en_i bit is 1 and the matching ab_drv_i and ab_obs_i bits differ. The 18-bit layout is: bit 0 arbitration-suppress, bit 1 lockout, bits 17:2 bank-available.
- R8: Bit 26 sets when cmd_ack_i arrives with no command of this node outstanding. An ack in the same cycle as a cmd_issue_i is not unexpected.
- R9: Bit 25 sets when dat_chk_i is high, dat_drv_i differs from dat_obs_i and ecc_err_i is low in that same cycle.
- R10: Bit 24 sets when data_err_i and xmtr_i are high together. It never raises fault_o.
- R11: fault_o is high exactly while any of bits 31..25 is set. Bits 23..0 always read 0.
- R12: A set flag holds until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for write-1-to-clear |
| wr_data_i | input | 32 | Clear mask |
| rd_data_o | output | 32 | Status word |
| fault_o | output | 1 | System fault |
| timeout_dis_i | input | 1 | Suppress the data timeout flag |
| wait_start_i | input | 1 | This node starts waiting for data |
| send_data_i | input | 1 | Responder signals data is coming |
| stat_valid_i | input | 1 | Status lines are valid this cycle |
| shared_i | input | 1 | Shared line |
| dirty_i | input | 1 | Dirty line |
| statchk_i | input | 1 | Status-check line |
| seq_valid_i | input | 1 | Completed transfer with sequence number |
| seq_i | input | 4 | Received sequence number |
| dc_drv_en_i | input | 10 | Data-control lines driven by this node |
| dc_drv_i | input | 10 | Data-control values driven |
| dc_obs_i | input | 10 | Data-control values observed |
| ab_drv_en_i | input | 18 | Address-side lines driven by this node |
| ab_drv_i | input | 18 | Address-side values driven |
| ab_obs_i | input | 18 | Address-side values observed |
| cmd_issue_i | input | 1 | This node issues a command |
| cmd_ack_i | input | 1 | Command acknowledge seen |
| dat_chk_i | input | 1 | Data transmit check active this cycle |
| dat_drv_i | input | DATA_W | Data driven |
| dat_obs_i | input | DATA_W | Data observed |
| ecc_err_i | input | 1 | ECC error in this transfer |
| data_err_i | input | 1 | Data-error indication |
| xmtr_i | input | 1 | This node transmits the current data |

## Verification
The assertions assume that the status-line inputs and the data-error/transmitter pair are settled at each rising edge. They also assume that timeout_dis_i acts on the edge at which it is sampled. The properties relate only the sampled inputs to the flag value one edge later. The bench changes every input on the falling edge and holds it for a full cycle. It drives single events that are separated by clear writes, and combines a set with a clear only in the deliberate collision case.

// File: rtl/bus_err_pkg.sv
package bus_err_pkg;
  localparam int REG_W = 32;
  localparam int SEQ_W = 4;
  localparam int DC_W  = 10;
  localparam int AB_W  = 18;

  localparam int B_TMO  = 31;
  localparam int B_STAT = 30;
  localparam int B_SEQ  = 29;
  localparam int B_DCTX = 28;
  localparam int B_ABTX = 27;
  localparam int B_UACK = 26;
  localparam int B_FDTX = 25;
  localparam int B_XMTR = 24;

  localparam logic [REG_W-1:0] FATAL_MASK = 32'hFE00_0000;
  localparam logic [REG_W-1:0] IMPL_MASK  = 32'hFF00_0000;
endpackage

// File: rtl/bes_wait_timer.sv
module bes_wait_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic dis_i,
  output logic expire_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic          waiting_q;
  logic [CW-1:0] cnt_q;
  logic          at_limit;

  assign at_limit = (cnt_q == CW'(LIMIT - 1));
  assign expire_o = waiting_q && !done_i && !start_i && at_limit && !dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q <= 1'b0;
      cnt_q     <= '0;
    end else if (start_i) begin
      waiting_q <= 1'b1;
      cnt_q     <= '0;
    end else if (waiting_q) begin
      if (done_i || at_limit) begin
        waiting_q <= 1'b0;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/bes_seq_track.sv
module bes_seq_track #(
  parameter int SEQ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SEQ_W-1:0] seq_i,
  output logic             err_o
);
  logic [SEQ_W-1:0] exp_q;

  assign err_o = valid_i && (seq_i != exp_q);

  // advances on every transfer, matching or not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      exp_q <= '0;
    else if (valid_i) exp_q <= exp_q + SEQ_W'(1);
  end
endmodule

// File: rtl/bes_tx_cmp.sv
module bes_tx_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] drv_i,
  input  logic [W-1:0] obs_i,
  output logic         err_o
);
  assign err_o = |(en_i & (drv_i ^ obs_i));
endmodule

// File: rtl/bes_ack_track.sv
module bes_ack_track #(
  parameter int MAX_OUT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic ack_i,
  output logic err_o
);
  localparam int AW = $clog2(MAX_OUT + 1);

  logic [AW-1:0] cnt_q;
  logic          idle;

  assign idle  = (cnt_q == '0);
  assign err_o = ack_i && !issue_i && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (issue_i && !ack_i) begin
      if (cnt_q < AW'(MAX_OUT)) cnt_q <= cnt_q + AW'(1);
    end else if (ack_i && !issue_i && !idle) begin
      cnt_q <= cnt_q - AW'(1);
    end
  end
endmodule

// File: rtl/bes_flag_bank.sv
module bes_flag_bank #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= set_i[i] | (q & ~(clr_en_i & clr_i[i])); // set wins
      end
      assign q_o[i] = q;
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/bus_err_status.sv
module bus_err_status
  import bus_err_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int TIMEOUT_CYC = 256,
  parameter int MAX_OUT     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  output logic              fault_o,
  input  logic              timeout_dis_i,
  input  logic              wait_start_i,
  input  logic              send_data_i,
  input  logic              stat_valid_i,
  input  logic              shared_i,
  input  logic              dirty_i,
  input  logic              statchk_i,
  input  logic              seq_valid_i,
  input  logic [3:0]        seq_i,
  input  logic [9:0]        dc_drv_en_i,
  input  logic [9:0]        dc_drv_i,
  input  logic [9:0]        dc_obs_i,
  input  logic [17:0]       ab_drv_en_i,
  input  logic [17:0]       ab_drv_i,
  input  logic [17:0]       ab_obs_i,
  input  logic              cmd_issue_i,
  input  logic              cmd_ack_i,
  input  logic              dat_chk_i,
  input  logic [DATA_W-1:0] dat_drv_i,
  input  logic [DATA_W-1:0] dat_obs_i,
  input  logic              ecc_err_i,
  input  logic              data_err_i,
  input  logic              xmtr_i
);
  logic tmo_ev, stat_ev, seq_ev, dc_ev, ab_ev, uack_ev, dat_mis, fdtx_ev, xmtr_ev;
  logic [REG_W-1:0] set_vec, flags;

  bes_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i, .rst_ni,
    .start_i (wait_start_i),
    .done_i  (send_data_i),
    .dis_i   (timeout_dis_i),
    .expire_o(tmo_ev)
  );

  assign stat_ev = stat_valid_i && (statchk_i != (shared_i | dirty_i));

  bes_seq_track #(.SEQ_W(SEQ_W)) u_seq (
    .clk_i, .rst_ni,
    .valid_i(seq_valid_i),
    .seq_i  (seq_i),
    .err_o  (seq_ev)
  );

  bes_tx_cmp #(.W(DC_W)) u_dc_cmp (
    .en_i(dc_drv_en_i), .drv_i(dc_drv_i), .obs_i(dc_obs_i), .err_o(dc_ev)
  );

  bes_tx_cmp #(.W(AB_W)) u_ab_cmp (
    .en_i(ab_drv_en_i), .drv_i(ab_drv_i), .obs_i(ab_obs_i), .err_o(ab_ev)
  );

  bes_tx_cmp #(.W(DATA_W)) u_dat_cmp (
    .en_i({DATA_W{dat_chk_i}}), .drv_i(dat_drv_i), .obs_i(dat_obs_i), .err_o(dat_mis)
  );

  // a transmit mismatch explained by an ECC error is not fatal here
  assign fdtx_ev = dat_mis && !ecc_err_i;

  bes_ack_track #(.MAX_OUT(MAX_OUT)) u_ack (
    .clk_i, .rst_ni,
    .issue_i(cmd_issue_i),
    .ack_i  (cmd_ack_i),
    .err_o  (uack_ev)
  );

  assign xmtr_ev = data_err_i && xmtr_i;

  always_comb begin
    set_vec         = '0;
    set_vec[B_TMO]  = tmo_ev;
    set_vec[B_STAT] = stat_ev;
    set_vec[B_SEQ]  = seq_ev;
    set_vec[B_DCTX] = dc_ev;
    set_vec[B_ABTX] = ab_ev;
    set_vec[B_UACK] = uack_ev;
    set_vec[B_FDTX] = fdtx_ev;
    set_vec[B_XMTR] = xmtr_ev;
  end

  bes_flag_bank #(.W(REG_W), .IMPL(IMPL_MASK)) u_flags (
    .clk_i, .rst_ni,
    .set_i   (set_vec),
    .clr_en_i(wr_en_i),
    .clr_i   (wr_data_i),
    .q_o     (flags)
  );

  assign rd_data_o = flags;
  assign fault_o   = |(flags & FATAL_MASK);
endmodule

// File: rtl/bus_err_status_chk.sv
module bus_err_status_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [2:0]  wr_sel_i, // {bit30, bit29, bit24} of the clear mask
  input logic [31:0] rd_data_o,
  input logic        fault_o,
  input logic        timeout_dis_i,
  input logic        stat_valid_i,
  input logic        shared_i,
  input logic        dirty_i,
  input logic        statchk_i,
  input logic        data_err_i,
  input logic        xmtr_i
);
  assert_set_beats_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_i && (statchk_i != (shared_i | dirty_i)) && wr_en_i && wr_sel_i[2])
      |=> rd_data_o[30]);

  assert_clear_works_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i[0] && !(data_err_i && xmtr_i)) |=> !rd_data_o[24]);

  assert_tmo_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_dis_i && !rd_data_o[31]) |=> !rd_data_o[31]);

  assert_stat_detect_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_i && (statchk_i != (shared_i | dirty_i))) |=> rd_data_o[30]);

  assert_status_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o == 32'h0100_0000) |-> !fault_o);

  assert_tmo_faults_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[31]) |-> fault_o);

  assert_unimpl_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[23:0] == 24'h0);

  assert_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[29] && !(wr_en_i && wr_sel_i[1])) |=> rd_data_o[29]);
endmodule

bind bus_err_status bus_err_status_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     ({wr_data_i[30], wr_data_i[29], wr_data_i[24]}),
  .rd_data_o    (rd_data_o),
  .fault_o      (fault_o),
  .timeout_dis_i(timeout_dis_i),
  .stat_valid_i (stat_valid_i),
  .shared_i     (shared_i),
  .dirty_i      (dirty_i),
  .statchk_i    (statchk_i),
  .data_err_i   (data_err_i),
  .xmtr_i       (xmtr_i)
);

// File: tb/bus_err_status_test.sv
module bus_err_status_test;
  localparam int DW  = 64;
  localparam int TMO = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [31:0]   wr_data_i = '0;
  logic [31:0]   rd_data_o;
  logic          fault_o;
  logic          timeout_dis_i = 1'b0, wait_start_i = 1'b0, send_data_i = 1'b0;
  logic          stat_valid_i = 1'b0, shared_i = 1'b0, dirty_i = 1'b0, statchk_i = 1'b0;
  logic          seq_valid_i = 1'b0;
  logic [3:0]    seq_i = '0;
  logic [9:0]    dc_drv_en_i = '0, dc_drv_i = '0, dc_obs_i = '0;
  logic [17:0]   ab_drv_en_i = '0, ab_drv_i = '0, ab_obs_i = '0;
  logic          cmd_issue_i = 1'b0, cmd_ack_i = 1'b0, dat_chk_i = 1'b0;
  logic [DW-1:0] dat_drv_i = '0, dat_obs_i = '0;
  logic          ecc_err_i = 1'b0, data_err_i = 1'b0, xmtr_i = 1'b0;

  int total = 0;
  int bad   = 0;

  always #4 clk_i = ~clk_i;

  bus_err_status #(.DATA_W(DW), .TIMEOUT_CYC(TMO), .MAX_OUT(4)) uut (.*);

  // {stat_v, shared, dirty, statchk, seq_v, seq[3:0], expected rd[31:24]}
  localparam logic [16:0] VEC [10] = '{
    {4'b1000, 1'b0, 4'd0, 8'h00},
    {4'b1101, 1'b0, 4'd0, 8'h00},
    {4'b1010, 1'b0, 4'd0, 8'h40},
    {4'b1111, 1'b0, 4'd0, 8'h00},
    {4'b1001, 1'b0, 4'd0, 8'h40},
    {4'b0000, 1'b1, 4'd0, 8'h00},
    {4'b0000, 1'b1, 4'd1, 8'h00},
    {4'b0000, 1'b1, 4'd5, 8'h20},
    {4'b0000, 1'b1, 4'd3, 8'h00},
    {4'b1100, 1'b1, 4'd4, 8'h40}
  };

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w1c(input logic [31:0] mask);
    wr_en_i = 1'b1; wr_data_i = mask;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 reset status", rd_data_o, 32'h0);
    chk("R1 reset fault", {31'h0, fault_o}, 32'h0);
    rst_ni = 1'b1;
    tick();
    chk("R1 after release", rd_data_o, 32'h0);

    // table: status and sequence patterns (R4, R5, R11, R2)
    for (int i = 0; i < 10; i++) begin
      {stat_valid_i, shared_i, dirty_i, statchk_i} = VEC[i][16:13];
      seq_valid_i = VEC[i][12];
      seq_i       = VEC[i][11:8];
      tick();
      {stat_valid_i, shared_i, dirty_i, statchk_i, seq_valid_i} = '0;
      seq_i = '0;
      chk("R4/R5 table flags", rd_data_o, {VEC[i][7:0], 24'h0});
      chk("R11 table fault", {31'h0, fault_o}, {31'h0, |VEC[i][7:0]});
      w1c(32'hFFFF_FFFF);
      chk("R2 table clear", rd_data_o, 32'h0);
    end

    // R5: 16 correct transfers wrap the expected number back to 5
    for (int k = 5; k < 21; k++) begin
      seq_valid_i = 1'b1; seq_i = 4'(k);
      tick();
    end
    seq_valid_i = 1'b0;
    chk("R5 wrap no error", rd_data_o, 32'h0);
    seq_valid_i = 1'b1; seq_i = 4'd4;
    tick();
    seq_valid_i = 1'b0;
    chk("R5 wrong after wrap", rd_data_o, 32'h2000_0000);
    // R12: held without clear
    repeat (5) tick();
    chk("R12 sticky", rd_data_o, 32'h2000_0000);
    w1c(32'h2000_0000);

    // R3: plain expiry
    wait_start_i = 1'b1; tick(); wait_start_i = 1'b0;
    repeat (TMO - 1) tick();
    chk("R3 not yet", rd_data_o, 32'h0);
    tick();
    chk("R3 expired", rd_data_o, 32'h8000_0000);
    chk("R11 timeout fault", {31'h0, fault_o}, 32'h1);
    w1c(32'hFFFF_FFFF);
    // R3: send_data ends the wait
    wait_start_i = 1'b1; tick(); wait_start_i = 1'b0;
    repeat (2) tick();
    send_data_i = 1'b1; tick(); send_data_i = 1'b0;
    repeat (TMO + 2) tick();
    chk("R3 data arrived", rd_data_o, 32'h0);
    // R3: restart
    wait_start_i = 1'b1; tick(); wait_start_i = 1'b0;
    repeat (TMO - 2) tick();
    wait_start_i = 1'b1; tick(); wait_start_i = 1'b0;
    repeat (TMO - 1) tick();
    chk("R3 restarted not yet", rd_data_o, 32'h0);
    tick();
    chk("R3 restarted expired", rd_data_o, 32'h8000_0000);
    w1c(32'hFFFF_FFFF);
    // R3: disabled
    timeout_dis_i = 1'b1;
    wait_start_i = 1'b1; tick(); wait_start_i = 1'b0;
    repeat (TMO + 3) tick();
    timeout_dis_i = 1'b0;
    chk("R3 disabled", rd_data_o, 32'h0);

    // R6
    dc_drv_en_i = 10'h000; dc_drv_i = 10'h3FF; dc_obs_i = 10'h000;
    tick();
    chk("R6 undriven mismatch", rd_data_o, 32'h0);
    dc_drv_en_i = 10'h008; dc_drv_i = 10'h008; dc_obs_i = 10'h008;
    tick();
    chk("R6 driven match", rd_data_o, 32'h0);
    dc_obs_i = 10'h000;
    tick();
    dc_drv_en_i = '0; dc_drv_i = '0;
    chk("R6 seq line mismatch", rd_data_o, 32'h1000_0000);
    w1c(32'hFFFF_FFFF);

    // R7
    ab_drv_en_i = 18'h00001; ab_drv_i = 18'h00002; ab_obs_i = 18'h00000;
    tick();
    chk("R7 lockout undriven", rd_data_o, 32'h0);
    ab_drv_en_i = 18'h00400; ab_drv_i = 18'h00400;
    tick();
    ab_drv_en_i = '0; ab_drv_i = '0;
    chk("R7 bank line mismatch", rd_data_o, 32'h0800_0000);
    w1c(32'hFFFF_FFFF);

    // R8
    cmd_issue_i = 1'b1; cmd_ack_i = 1'b1; tick();
    cmd_issue_i = 1'b0; cmd_ack_i = 1'b0;
    chk("R8 ack with issue", rd_data_o, 32'h0);
    cmd_issue_i = 1'b1; tick(); cmd_issue_i = 1'b0;
    cmd_ack_i = 1'b1; tick(); cmd_ack_i = 1'b0;
    chk("R8 expected ack", rd_data_o, 32'h0);
    cmd_ack_i = 1'b1; tick(); cmd_ack_i = 1'b0;
    chk("R8 unexpected ack", rd_data_o, 32'h0400_0000);
    w1c(32'hFFFF_FFFF);

    // R9
    dat_drv_i = 64'h1; dat_obs_i = 64'h0; dat_chk_i = 1'b0;
    tick();
    chk("R9 check inactive", rd_data_o, 32'h0);
    dat_chk_i = 1'b1; ecc_err_i = 1'b1;
    tick();
    chk("R9 ecc explains", rd_data_o, 32'h0);
    ecc_err_i = 1'b0; dat_drv_i = 64'h8000_0000_0000_0000;
    tick();
    dat_chk_i = 1'b0; dat_drv_i = '0;
    chk("R9 fatal data tx", rd_data_o, 32'h0200_0000);
    w1c(32'hFFFF_FFFF);

    // R10
    data_err_i = 1'b1; tick();
    chk("R10 not transmitter", rd_data_o, 32'h0);
    xmtr_i = 1'b1; tick();
    data_err_i = 1'b0; xmtr_i = 1'b0;
    chk("R10 transmitter flag", rd_data_o, 32'h0100_0000);
    chk("R10 no fault", {31'h0, fault_o}, 32'h0);
    w1c(32'hFFFF_FFFF);

    // R2 collision: set and clear in one cycle
    stat_valid_i = 1'b1; shared_i = 1'b1; statchk_i = 1'b0;
    wr_en_i = 1'b1; wr_data_i = 32'h4000_0000;
    tick();
    stat_valid_i = 1'b0; shared_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    chk("R2 set wins", rd_data_o, 32'h4000_0000);
    // R11/R2 partial clear
    cmd_ack_i = 1'b1; tick(); cmd_ack_i = 1'b0;
    w1c(32'h4000_0000);
    chk("R2 partial clear", rd_data_o, 32'h0400_0000);
    chk("R11 fault held", {31'h0, fault_o}, 32'h1);
    w1c(32'h0400_0000);
    chk("R11 fault released", {31'h0, fault_o}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule